// File: doc/BRIEF.md
# Parallel Bank Conflict Checker

This block models the storage side of a parallel iterative decoder. `NUM_PE` processing lanes share an equal number of memory banks, and together they sweep a frame of `FRAME_LEN` data elements. After a start pulse, the block walks through one full iteration, one access step per clock. The first half of the iteration is the natural sweep. The second half is the interleaved sweep, whose access matrix is the transpose of the natural one.

In each step, every lane is given a data index. The block splits that index into a bank number and a local address, using a single fixed placement in which each bank holds one contiguous slice of the frame. In the same cycle, the block reports how many lanes land on each bank and raises a flag when any bank is hit more than once. It also keeps a count of the steps that collided. A designer uses it to see, step by step, where a given placement forces serialisation. It does not arbitrate the collisions.

Top module: `bank_conflict_checker`

## Requirements
- R1: While `rst_ni` is low and after its release, until the first start, `valid_o`, `done_o`, `conflict_o`, `hits_o` and `conf_total_o` are all zero.
- R2: A cycle with `start_i` high makes the next cycle show `valid_o`=1, `phase_o`=0 and `step_o`=0. `valid_o` then stays high for exactly 2*M consecutive cycles, where M = FRAME_LEN/NUM_PE, and `step_o` counts 0..M-1 within each phase.
- R3: While `phase_o`=0, lane p at step t addresses element p*M + t.
- R4: While `phase_o`=1, lane p at step t addresses element t*NUM_PE + p. The M interleaved steps directly follow the M natural steps.
- R5: Element d sits in bank d/M (integer division) at local address d mod M. Lane p's bank is `bank_o[p*BW +: BW]` with BW = clog2(NUM_PE), and its address is `addr_o[p*AW +: AW]` with AW = clog2(M). Natural steps therefore never collide.
- R6: `hits_o[b*CW +: CW]`, with CW = clog2(NUM_PE)+1, equals the number of lanes that target bank b in the current step. It is valid in the same cycle as the request vector, and the counts sum to NUM_PE.
- R7: `conflict_o` is high in exactly those valid cycles in which some bank count is 2 or more. It is low whenever `valid_o` is low.
- R8: `done_o` is a one-cycle pulse in the cycle after the last interleaved step. `valid_o` is low in that cycle.
- R9: `conf_total_o` increases by one for each valid cycle with `conflict_o` high, and holds its value after `done_o`. For the default 4 lanes and 20 elements it ends at 5.
- R10: A start pulse during a running frame restarts at natural step 0 and clears `conf_total_o` to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts or restarts an iteration |
| valid_o | output | 1 | Request vector of this cycle is live |
| phase_o | output | 1 | 0 natural sweep, 1 interleaved sweep |
| step_o | output | clog2(M) | Step within the current phase |
| bank_o | output | NUM_PE*BW | Per-lane bank number |
| addr_o | output | NUM_PE*AW | Per-lane local address |
| hits_o | output | NUM_PE*CW | Per-bank lane count this step |
| conflict_o | output | 1 | Some bank hit by two or more lanes |
| done_o | output | 1 | One-cycle end-of-iteration pulse |
| conf_total_o | output | clog2(2M+1) | Colliding steps in the current iteration |

## Verification
The start pulse is registered once. Step 0 therefore appears one cycle after start is sampled, and each later step follows one cycle after the one before it. Bank, address, hit counts and conflict flag are combinational from the step state, so they are due in the same cycle as their step. The done pulse comes one cycle after the last step. The collision total is a register and shows each colliding step one cycle after that step.

The bench drives start just after a falling edge. It queues one expected record per step and pops one record at every falling edge on which `valid_o` is high. It checks done and the total at the falling edge 2*M cycles after step 0. A restart flushes the queue before the edge that samples the new start.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  typedef enum logic {
    PH_NAT = 1'b0,
    PH_ILV = 1'b1
  } phase_e;
endpackage

// File: rtl/bcc_step_seq.sv
module bcc_step_seq #(
  parameter int HALF = 5,
  parameter int SW   = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  output logic           valid_o,
  output bcc_pkg::phase_e phase_o,
  output logic [SW-1:0]  step_o,
  output logic           done_o
);
  import bcc_pkg::*;

  localparam logic [SW-1:0] LAST = SW'(HALF - 1);

  logic          active_q;
  phase_e        phase_q;
  logic [SW-1:0] step_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      phase_q  <= PH_NAT;
      step_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        active_q <= 1'b1;
        phase_q  <= PH_NAT;
        step_q   <= '0;
      end else if (active_q) begin
        if (step_q == LAST) begin
          step_q <= '0;
          if (phase_q == PH_ILV) begin
            active_q <= 1'b0;
            phase_q  <= PH_NAT;
            done_q   <= 1'b1;
          end else begin
            phase_q <= PH_ILV;
          end
        end else begin
          step_q <= step_q + SW'(1);
        end
      end
    end
  end

  assign valid_o = active_q;
  assign phase_o = phase_q;
  assign step_o  = step_q;
  assign done_o  = done_q;

  assert_first_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (valid_o && step_o == '0 && phase_o == PH_NAT));

  assert_phase_switch_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i && phase_o == PH_NAT && step_o == LAST)
      |=> (valid_o && phase_o == PH_ILV && step_o == '0));

  assert_done_after_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i && phase_o == PH_ILV && step_o == LAST) |=> (done_o && !valid_o));

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/bcc_index_gen.sv
module bcc_index_gen #(
  parameter int NUM_PE = 4,
  parameter int HALF   = 5,
  parameter int SW     = 3,
  parameter int IW     = 5
) (
  input  bcc_pkg::phase_e       phase_i,
  input  logic [SW-1:0]         step_i,
  output logic [NUM_PE*IW-1:0]  idx_o
);
  import bcc_pkg::*;

  for (genvar p = 0; p < NUM_PE; p++) begin : g_lane
    logic [IW-1:0] nat_idx;
    logic [IW-1:0] ilv_idx;
    // natural: row-major per lane; interleaved: transposed matrix
    assign nat_idx = IW'(p * HALF) + IW'(step_i);
    assign ilv_idx = IW'(step_i) * IW'(NUM_PE) + IW'(p);
    assign idx_o[p*IW +: IW] = (phase_i == PH_ILV) ? ilv_idx : nat_idx;
  end
endmodule

// File: rtl/bcc_bank_map.sv
module bcc_bank_map #(
  parameter int NUM_PE = 4,
  parameter int HALF   = 5,
  parameter int IW     = 5,
  parameter int BW     = 2,
  parameter int AW     = 3
) (
  input  logic [NUM_PE*IW-1:0] idx_i,
  output logic [NUM_PE*BW-1:0] bank_o,
  output logic [NUM_PE*AW-1:0] addr_o
);
  localparam logic [IW-1:0] SLICE = IW'(HALF);

  for (genvar p = 0; p < NUM_PE; p++) begin : g_lane
    logic [IW-1:0] d;
    assign d = idx_i[p*IW +: IW];
    assign bank_o[p*BW +: BW] = BW'(d / SLICE);
    assign addr_o[p*AW +: AW] = AW'(d % SLICE);
  end
endmodule

// File: rtl/bcc_conflict_det.sv
module bcc_conflict_det #(
  parameter int NUM_PE = 4,
  parameter int BW     = 2,
  parameter int CW     = 3,
  parameter int TW     = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 valid_i,
  input  logic [NUM_PE*BW-1:0] bank_i,
  output logic [NUM_PE*CW-1:0] hits_o,
  output logic                 conflict_o,
  output logic [TW-1:0]        total_o
);
  logic [TW-1:0]     total_q;
  logic [NUM_PE-1:0] multi;

  for (genvar b = 0; b < NUM_PE; b++) begin : g_bank
    logic [CW-1:0] cnt;
    always_comb begin
      cnt = '0;
      for (int p = 0; p < NUM_PE; p++) begin
        if (valid_i && bank_i[p*BW +: BW] == BW'(b)) cnt = cnt + CW'(1);
      end
    end
    assign hits_o[b*CW +: CW] = cnt;
    assign multi[b] = (cnt > CW'(1));
  end

  assign conflict_o = |multi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       total_q <= '0;
    else if (start_i)                  total_q <= '0;
    else if (valid_i && conflict_o)    total_q <= total_q + TW'(1);
  end

  assign total_o = total_q;

  assert_total_inc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && conflict_o && !start_i) |=> (total_o == $past(total_o) + TW'(1)));

  assert_total_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !start_i) |=> $stable(total_o));

  assert_total_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (total_o == '0));
endmodule

// File: rtl/bank_conflict_checker.sv
module bank_conflict_checker #(
  parameter int NUM_PE    = 4,
  parameter int FRAME_LEN = 20,
  localparam int HALF  = FRAME_LEN / NUM_PE,
  localparam int STEPS = 2 * HALF,
  localparam int SW    = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int AW    = SW,
  localparam int BW    = (NUM_PE > 1) ? $clog2(NUM_PE) : 1,
  localparam int IW    = $clog2(FRAME_LEN),
  localparam int CW    = $clog2(NUM_PE) + 1,
  localparam int TW    = $clog2(STEPS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  output logic                 valid_o,
  output logic                 phase_o,
  output logic [SW-1:0]        step_o,
  output logic [NUM_PE*BW-1:0] bank_o,
  output logic [NUM_PE*AW-1:0] addr_o,
  output logic [NUM_PE*CW-1:0] hits_o,
  output logic                 conflict_o,
  output logic                 done_o,
  output logic [TW-1:0]        conf_total_o
);
  import bcc_pkg::*;

  phase_e               phase;
  logic [NUM_PE*IW-1:0] idx;

  bcc_step_seq #(.HALF(HALF), .SW(SW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .valid_o (valid_o),
    .phase_o (phase),
    .step_o  (step_o),
    .done_o  (done_o)
  );

  bcc_index_gen #(.NUM_PE(NUM_PE), .HALF(HALF), .SW(SW), .IW(IW)) u_idx (
    .phase_i (phase),
    .step_i  (step_o),
    .idx_o   (idx)
  );

  bcc_bank_map #(.NUM_PE(NUM_PE), .HALF(HALF), .IW(IW), .BW(BW), .AW(AW)) u_map (
    .idx_i  (idx),
    .bank_o (bank_o),
    .addr_o (addr_o)
  );

  bcc_conflict_det #(.NUM_PE(NUM_PE), .BW(BW), .CW(CW), .TW(TW)) u_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .valid_i    (valid_o),
    .bank_i     (bank_o),
    .hits_o     (hits_o),
    .conflict_o (conflict_o),
    .total_o    (conf_total_o)
  );

  assign phase_o = phase;

  function automatic int hit_sum(logic [NUM_PE*CW-1:0] h);
    int s = 0;
    for (int b = 0; b < NUM_PE; b++) s += int'(h[b*CW +: CW]);
    return s;
  endfunction

  assert_natural_clean_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !phase_o) |-> !conflict_o);

  assert_hit_sum_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (hit_sum(hits_o) == NUM_PE));

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!conflict_o && hits_o == '0));
endmodule

// File: tb/bank_conflict_checker_tb.sv
module bank_conflict_checker_tb;
  localparam int P     = 4;
  localparam int L     = 20;
  localparam int M     = L / P;
  localparam int T     = 2 * M;
  localparam int SW    = $clog2(M);
  localparam int AW    = SW;
  localparam int BW    = $clog2(P);
  localparam int CW    = $clog2(P) + 1;
  localparam int TW    = $clog2(T + 1);

  typedef struct {
    logic          phase;
    logic [SW-1:0] step;
    logic [P*BW-1:0] bank;
    logic [P*AW-1:0] addr;
    logic [P*CW-1:0] hits;
    logic          conflict;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic valid_o, phase_o, conflict_o, done_o;
  logic [SW-1:0]   step_o;
  logic [P*BW-1:0] bank_o;
  logic [P*AW-1:0] addr_o;
  logic [P*CW-1:0] hits_o;
  logic [TW-1:0]   conf_total_o;

  int n_checks = 0;
  int n_fails  = 0;
  exp_t exp_q[$];

  always #5 clk_i = ~clk_i;

  bank_conflict_checker #(.NUM_PE(P), .FRAME_LEN(L)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .valid_o(valid_o), .phase_o(phase_o), .step_o(step_o),
    .bank_o(bank_o), .addr_o(addr_o), .hits_o(hits_o),
    .conflict_o(conflict_o), .done_o(done_o), .conf_total_o(conf_total_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic exp_t make_exp(input int k);
    exp_t e;
    int t, d, b;
    int cnt[P];
    e.phase = (k >= M);
    t = k % M;
    e.step = SW'(t);
    for (int i = 0; i < P; i++) cnt[i] = 0;
    for (int p = 0; p < P; p++) begin
      d = e.phase ? (t * P + p) : (p * M + t);   // R3 / R4
      b = d / M;                                 // R5
      e.bank[p*BW +: BW] = BW'(b);
      e.addr[p*AW +: AW] = AW'(d % M);
      cnt[b]++;
    end
    e.conflict = 1'b0;
    for (int i = 0; i < P; i++) begin
      e.hits[i*CW +: CW] = CW'(cnt[i]);
      if (cnt[i] > 1) e.conflict = 1'b1;
    end
    return e;
  endfunction

  function automatic int frame_total();
    int s = 0;
    exp_t e;
    for (int k = 0; k < T; k++) begin
      e = make_exp(k);
      if (e.conflict) s++;
    end
    return s;
  endfunction

  // driver: start pulse plus expected items for one iteration
  task automatic start_frame();
    @(negedge clk_i); #1;
    start_i = 1'b1;
    exp_q.delete();
    for (int k = 0; k < T; k++) exp_q.push_back(make_exp(k));
    @(negedge clk_i); #1;
    start_i = 1'b0;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected valid", 64'(valid_o), 64'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(phase_o == e.phase, "R4 phase", 64'(phase_o), 64'(e.phase));
        chk(step_o == e.step, "R2 step", 64'(step_o), 64'(e.step));
        chk(bank_o == e.bank, "R5 bank (R3/R4 order)", 64'(bank_o), 64'(e.bank));
        chk(addr_o == e.addr, "R5 addr", 64'(addr_o), 64'(e.addr));
        chk(hits_o == e.hits, "R6 hits", 64'(hits_o), 64'(e.hits));
        chk(conflict_o == e.conflict, "R7 conflict", 64'(conflict_o), 64'(e.conflict));
      end
    end
  end

  task automatic check_idle(input string tag);
    chk(valid_o == 1'b0, tag, 64'(valid_o), 64'd0);
    chk(conflict_o == 1'b0 && hits_o == '0, "R7 idle quiet", 64'(hits_o), 64'd0);
  endtask

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 during reset
    chk(valid_o == 0 && done_o == 0, "R1 reset outputs", 64'({valid_o, done_o}), 64'd0);
    chk(conf_total_o == '0, "R1 reset total", 64'(conf_total_o), 64'd0);
    #1 rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check_idle("R1 idle after reset");
    chk(done_o == 0 && conf_total_o == '0, "R1 done/total after reset", 64'(conf_total_o), 64'd0);

    // full iteration
    start_frame();
    repeat (T) @(negedge clk_i);
    chk(done_o == 1'b1, "R8 done pulse", 64'(done_o), 64'd1);
    chk(valid_o == 1'b0, "R8 valid low at done", 64'(valid_o), 64'd0);
    chk(conf_total_o == TW'(frame_total()), "R9 total", 64'(conf_total_o), 64'(frame_total()));
    chk(conf_total_o == TW'(5), "R9 default total", 64'(conf_total_o), 64'd5);
    chk(exp_q.size() == 0, "R2 frame length", 64'(exp_q.size()), 64'd0);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R8 done single", 64'(done_o), 64'd0);
    repeat (3) @(negedge clk_i);
    check_idle("R2 idle after frame");
    chk(conf_total_o == TW'(5), "R9 total held", 64'(conf_total_o), 64'd5);

    // restart mid-frame during interleaved phase
    start_frame();
    repeat (M + 1) @(negedge clk_i);
    chk(conf_total_o != '0, "R9 partial total nonzero", 64'(conf_total_o), 64'd1);
    start_frame();
    chk(conf_total_o == '0, "R10 total cleared", 64'(conf_total_o), 64'd0);
    chk(step_o == '0 && phase_o == 1'b0, "R10 restart step", 64'(step_o), 64'd0);
    repeat (T) @(negedge clk_i);
    chk(done_o == 1'b1, "R10 done after restart", 64'(done_o), 64'd1);
    chk(conf_total_o == TW'(frame_total()), "R10 total after restart", 64'(conf_total_o), 64'(frame_total()));
    chk(exp_q.size() == 0, "R10 queue drained", 64'(exp_q.size()), 64'd0);

    repeat (2) @(negedge clk_i);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule